// File: doc/BRIEF.md
# AC-Link Output Frame Assembler

This block builds the outgoing serial frame of an AC-Link audio codec interface and shifts it out one bit per clock. Every frame is 256 bit clocks long. It opens with a 16-bit tag slot, followed by twelve 20-bit slots, and all bits go out most significant bit first. The tag slot reports which of the following slots carry meaningful content. One extra bit flags the frame as a whole as valid.

Slots 1 and 2 carry a codec register command: an address word and a data word. They are filled only when a command is offered at the frame boundary. Slots 3 to 12 carry PCM samples. These come from two transmit channels, A and B. Each channel has a one-entry holding register with a valid/ready handshake. A per-slot assignment map, given on an input port, routes each of these ten slots to channel A, to channel B, or to neither. The map and the command are captured once per frame, at the frame boundary. Each channel gives up at most one sample per frame, placed in the first slot assigned to it.

The block is clocked directly by the bit clock. It drives the frame sync and the serial data outputs.

Top module: `aclink_tx_framer`

## Requirements
- R1: A frame lasts exactly 256 clocks. `ac_sync` is high for 16 consecutive clocks per frame: the clock before the first tag bit and the first 15 tag-bit clocks.
- R2: The tag slot is 16 bits. Bit 15 (sent first) is the frame-valid flag and is set exactly when any other tag bit is set. Bit 15-s marks slot s valid for s in 1..12. Bits 2..0 are zero.
- R3: `cmd_ready` is high only in the clock before a frame's first tag bit. If `cmd_valid` is high then, tag bits 14 and 13 are set, slot 1 carries `cmd_addr` and slot 2 carries `cmd_data`. Otherwise both tag bits and both slots are zero.
- R4: `slot_map` holds a 2-bit code per PCM slot. Slot k (3..12) uses bits [2(k-3)+1 : 2(k-3)]. Code 01 selects channel A, code 10 selects channel B, and codes 00 and 11 leave the slot unused.
- R5: A PCM slot is valid only if it is the lowest-numbered slot mapped to its channel and that channel's holding register is full at the frame boundary. A valid slot carries the held sample. Every other PCM slot is sent as zeros with its tag bit clear.
- R6: `pcm_ready[c]` is high exactly when channel c's holding register is empty. A sample is taken when valid and ready are both high. A write offered while the register is full is ignored, and the held sample is unchanged.
- R7: A channel's sample is consumed at the clock that starts its valid slot, and `pcm_ready` reasserts from that clock on. A full channel that has no slot mapped to it keeps its sample.
- R8: Changes to `slot_map`, `cmd_addr` or `cmd_data` after the frame boundary do not alter the frame being sent.
- R9: During reset `ac_sync` and `ac_sdata` are low, `cmd_ready` is low and both `pcm_ready` bits are high. The first frame's sync rises at the first clock after reset is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_map | input | 20 | 2-bit channel code for each of PCM slots 3..12 |
| cmd_valid | input | 1 | Codec register command offered |
| cmd_addr | input | 20 | Command address word for slot 1 |
| cmd_data | input | 20 | Command data word for slot 2 |
| cmd_ready | output | 1 | Command accepted this clock (frame boundary) |
| pcm_valid | input | 2 | Sample offered, bit 0 channel A, bit 1 channel B |
| pcm_data | input | 40 | Samples, channel A in [19:0], channel B in [39:20] |
| pcm_ready | output | 2 | Holding register empty, per channel |
| ac_sync | output | 1 | Frame sync |
| ac_sdata | output | 1 | Serial frame data, MSB first |

## Verification
The bench builds the block with its default widths: a 16-bit tag slot and 20-bit data slots, which gives the 256-clock frame. At these widths all ten PCM slot positions, both channel codes and both unused codes can be driven. This includes a map that points every slot at one channel and a map that uses only slot 12. About fifty frames fit in a short run. Across them the bench holds channels full across frames in which they have no mapped slot, rewrites the map in the middle of a frame, and checks the exact clock at which each ready flag returns.

// File: rtl/aclink_tx_pkg.sv
`timescale 1ns/1ps
package aclink_tx_pkg;
    localparam int unsigned NUM_SLOTS = 13;
    localparam int unsigned FIRST_PCM = 3;
    localparam int unsigned NUM_PCM   = NUM_SLOTS - FIRST_PCM;
    localparam int unsigned NUM_CH    = 2;
    localparam int unsigned CODE_W    = 2;
    localparam int unsigned MAP_W     = CODE_W * NUM_PCM;

    typedef enum logic [CODE_W-1:0] {
        SEL_OFF  = 2'b00,
        SEL_A    = 2'b01,
        SEL_B    = 2'b10,
        SEL_OFF2 = 2'b11
    } chan_sel_e;
endpackage

// File: rtl/aclink_frame_timer.sv
`timescale 1ns/1ps
module aclink_frame_timer
    import aclink_tx_pkg::*;
#(
    parameter int unsigned TAG_W  = 16,
    parameter int unsigned SLOT_W = 20
) (
    input  logic       clk,
    input  logic       rst_n,
    output logic       frame_edge,
    output logic       slot_load,
    output logic [3:0] slot_next,
    output logic       sync
);
    localparam int unsigned CNT_W = $clog2(SLOT_W);
    localparam logic [CNT_W-1:0] TAG_LAST  = CNT_W'(TAG_W - 1);
    localparam logic [CNT_W-1:0] SLOT_LAST = CNT_W'(SLOT_W - 1);
    localparam logic [3:0]       LAST_SLOT = 4'(NUM_SLOTS - 1);

    typedef struct packed {
        logic [3:0]       slot;
        logic [CNT_W-1:0] bit_i;
        logic             sync;
    } tmr_t;

    tmr_t t_q, t_d;
    logic last_bit;

    always_comb begin
        t_d      = t_q;
        last_bit = (t_q.slot == 4'd0) ? (t_q.bit_i == TAG_LAST) : (t_q.bit_i == SLOT_LAST);
        if (last_bit) begin
            t_d.bit_i = '0;
            t_d.slot  = (t_q.slot == LAST_SLOT) ? 4'd0 : t_q.slot + 4'd1;
        end else begin
            t_d.bit_i = t_q.bit_i + 1'b1;
        end
        t_d.sync = ((t_d.slot == 4'd0) && (t_d.bit_i < TAG_LAST)) ||
                   ((t_d.slot == LAST_SLOT) && (t_d.bit_i == SLOT_LAST));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            t_q.slot  <= LAST_SLOT;
            t_q.bit_i <= CNT_W'(SLOT_W - 2);
            t_q.sync  <= 1'b0;
        end else begin
            t_q <= t_d;
        end
    end

    assign frame_edge = last_bit && (t_q.slot == LAST_SLOT);
    assign slot_load  = last_bit;
    assign slot_next  = t_d.slot;
    assign sync       = t_q.sync;
endmodule

// File: rtl/aclink_tag_builder.sv
`timescale 1ns/1ps
module aclink_tag_builder
    import aclink_tx_pkg::*;
#(
    parameter int unsigned TAG_W = 16
) (
    input  logic [MAP_W-1:0]  slot_map,
    input  logic [NUM_CH-1:0] ch_full,
    input  logic              cmd_pending,
    output logic [TAG_W-1:0]  tag
);
    always_comb begin
        logic [NUM_CH-1:0] seen;
        logic [CODE_W-1:0] code;
        tag  = '0;
        seen = '0;
        code = '0;
        tag[TAG_W-2] = cmd_pending;
        tag[TAG_W-3] = cmd_pending;
        for (int i = 0; i < int'(NUM_PCM); i++) begin
            code = slot_map[CODE_W*i +: CODE_W];
            for (int c = 0; c < int'(NUM_CH); c++) begin
                if (code == CODE_W'(c + 1)) begin
                    if (ch_full[c] && !seen[c]) begin
                        tag[TAG_W-1-int'(FIRST_PCM)-i] = 1'b1;
                    end
                    seen[c] = 1'b1;
                end
            end
        end
        tag[TAG_W-1] = |tag[TAG_W-2:0];
    end
endmodule

// File: rtl/aclink_tx_hold.sv
`timescale 1ns/1ps
module aclink_tx_hold #(
    parameter int unsigned W = 20
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [W-1:0] in_data,
    output logic         in_ready,
    input  logic         take,
    output logic         full,
    output logic [W-1:0] data
);
    typedef struct packed {
        logic         full;
        logic [W-1:0] data;
    } hold_t;

    hold_t h_q, h_d;

    always_comb begin
        h_d = h_q;
        if (in_valid && !h_q.full) begin
            h_d.full = 1'b1;
            h_d.data = in_data;
        end else if (take) begin
            h_d.full = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            h_q <= '0;
        end else begin
            h_q <= h_d;
        end
    end

    assign in_ready = !h_q.full;
    assign full     = h_q.full;
    assign data     = h_q.data;
endmodule

// File: rtl/aclink_tx_framer.sv
`timescale 1ns/1ps
module aclink_tx_framer
    import aclink_tx_pkg::*;
#(
    parameter int unsigned TAG_W  = 16,
    parameter int unsigned SLOT_W = 20
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [MAP_W-1:0]         slot_map,
    input  logic                     cmd_valid,
    input  logic [SLOT_W-1:0]        cmd_addr,
    input  logic [SLOT_W-1:0]        cmd_data,
    output logic                     cmd_ready,
    input  logic [NUM_CH-1:0]        pcm_valid,
    input  logic [NUM_CH*SLOT_W-1:0] pcm_data,
    output logic [NUM_CH-1:0]        pcm_ready,
    output logic                     ac_sync,
    output logic                     ac_sdata
);
    typedef struct packed {
        logic [TAG_W-1:0]  tag;
        logic [MAP_W-1:0]  map;
        logic [SLOT_W-1:0] addr;
        logic [SLOT_W-1:0] data;
        logic [SLOT_W-1:0] shreg;
    } frame_t;

    frame_t f_q, f_d;

    logic                           frame_edge;
    logic                           slot_load;
    logic [3:0]                     slot_next;
    logic [TAG_W-1:0]               tag_new;
    logic [NUM_CH-1:0]              full_w;
    logic [NUM_CH-1:0]              take_d;
    logic [NUM_CH-1:0][SLOT_W-1:0]  hold_q;

    aclink_frame_timer #(.TAG_W(TAG_W), .SLOT_W(SLOT_W)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_edge (frame_edge),
        .slot_load  (slot_load),
        .slot_next  (slot_next),
        .sync       (ac_sync)
    );

    aclink_tag_builder #(.TAG_W(TAG_W)) u_tag (
        .slot_map    (slot_map),
        .ch_full     (full_w),
        .cmd_pending (cmd_valid),
        .tag         (tag_new)
    );

    for (genvar c = 0; c < int'(NUM_CH); c++) begin : g_hold
        aclink_tx_hold #(.W(SLOT_W)) u_hold (
            .clk      (clk),
            .rst_n    (rst_n),
            .in_valid (pcm_valid[c]),
            .in_data  (pcm_data[c*SLOT_W +: SLOT_W]),
            .in_ready (pcm_ready[c]),
            .take     (take_d[c]),
            .full     (full_w[c]),
            .data     (hold_q[c])
        );
    end

    // Slot content is chosen at each slot boundary; the shift register
    // then walks it out one bit per clock, MSB first.
    always_comb begin
        logic [SLOT_W-1:0] word;
        logic [CODE_W-1:0] code;
        int                s;
        f_d    = f_q;
        take_d = '0;
        word   = '0;
        code   = '0;
        s      = int'(slot_next);
        if (slot_load) begin
            if (frame_edge) begin
                f_d.tag  = tag_new;
                f_d.map  = slot_map;
                f_d.addr = cmd_valid ? cmd_addr : '0;
                f_d.data = cmd_valid ? cmd_data : '0;
                word     = SLOT_W'(tag_new) << (SLOT_W - TAG_W);
            end else if (s == 1) begin
                word = f_q.addr;
            end else if (s == 2) begin
                word = f_q.data;
            end else begin
                code = f_q.map[CODE_W*(s-int'(FIRST_PCM)) +: CODE_W];
                if (f_q.tag[TAG_W-1-s]) begin
                    for (int c = 0; c < int'(NUM_CH); c++) begin
                        if (code == CODE_W'(c + 1)) begin
                            word      = hold_q[c];
                            take_d[c] = 1'b1;
                        end
                    end
                end
            end
            f_d.shreg = word;
        end else begin
            f_d.shreg = f_q.shreg << 1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            f_q <= '0;
        end else begin
            f_q <= f_d;
        end
    end

    assign cmd_ready = frame_edge;
    assign ac_sdata  = f_q.shreg[SLOT_W-1];
endmodule

// File: rtl/aclink_tx_framer_chk.sv
`timescale 1ns/1ps
module aclink_tx_framer_chk
    import aclink_tx_pkg::*;
#(
    parameter int unsigned TAG_W  = 16,
    parameter int unsigned SLOT_W = 20
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          sync,
    input logic                          cmd_ready,
    input logic [NUM_CH-1:0]             pcm_valid,
    input logic [NUM_CH-1:0]             pcm_ready,
    input logic [NUM_CH-1:0][SLOT_W-1:0] hold
);
    localparam int unsigned FRAME_LEN = TAG_W + (NUM_SLOTS - 1) * SLOT_W;
    localparam int unsigned PW = $clog2(FRAME_LEN) + 1;

    logic [PW-1:0] run_q;
    logic [PW-1:0] per_q;
    logic          sync_prev_q;
    logic          seen_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q       <= '0;
            per_q       <= '0;
            sync_prev_q <= 1'b0;
            seen_q      <= 1'b0;
        end else begin
            run_q       <= sync ? run_q + 1'b1 : '0;
            per_q       <= (sync && !sync_prev_q) ? '0 : per_q + 1'b1;
            sync_prev_q <= sync;
            if (sync && !sync_prev_q) seen_q <= 1'b1;
        end
    end

    // R1
    sync_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(sync) |-> run_q == PW'(TAG_W)) and (sync |-> run_q < PW'(TAG_W)));

    // R1
    frame_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sync && !sync_prev_q && seen_q) |-> per_q == PW'(FRAME_LEN - 1));

    // R3
    cmd_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> (sync && !sync_prev_q));

    for (genvar c = 0; c < int'(NUM_CH); c++) begin : g_ch
        // R6
        accept_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (pcm_valid[c] && pcm_ready[c]) |=> !pcm_ready[c]);

        // R6
        hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!pcm_ready[c] && !$past(pcm_ready[c])) |-> $stable(hold[c]));
    end
endmodule

bind aclink_tx_framer aclink_tx_framer_chk #(.TAG_W(TAG_W), .SLOT_W(SLOT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sync      (ac_sync),
    .cmd_ready (cmd_ready),
    .pcm_valid (pcm_valid),
    .pcm_ready (pcm_ready),
    .hold      (hold_q)
);

// File: tb/sim_aclink_tx_framer.sv
`timescale 1ns/1ps
module sim_aclink_tx_framer;
    localparam int NFR = 48;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [19:0] slot_map = '0;
    logic        cmd_valid = 1'b0;
    logic [19:0] cmd_addr = '0;
    logic [19:0] cmd_data = '0;
    logic        cmd_ready;
    logic [1:0]  pcm_valid = '0;
    logic [39:0] pcm_data = '0;
    logic [1:0]  pcm_ready;
    logic        ac_sync;
    logic        ac_sdata;

    always #10 clk = ~clk;

    aclink_tx_framer u0 (
        .clk(clk), .rst_n(rst_n), .slot_map(slot_map), .cmd_valid(cmd_valid),
        .cmd_addr(cmd_addr), .cmd_data(cmd_data), .cmd_ready(cmd_ready),
        .pcm_valid(pcm_valid), .pcm_data(pcm_data), .pcm_ready(pcm_ready),
        .ac_sync(ac_sync), .ac_sdata(ac_sdata)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;

    bit        m_full [2];
    logic [19:0] m_data [2];

    task automatic check(input bit ok, input string req, input logic [255:0] act, input logic [255:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Expected frame from the requirements: tag (R2), command slots (R3),
    // map codes (R4) and first-slot-per-channel validity (R5).
    task automatic predict(input logic [19:0] map, input bit cmd, input logic [19:0] a,
                           input logic [19:0] d, output logic [255:0] frame, output int first [2]);
        logic [15:0] tag;
        logic [1:0]  code;
        bit          seen [2];
        tag = '0; seen = '{0, 0}; first = '{0, 0}; frame = '0;
        if (cmd) begin tag[14] = 1'b1; tag[13] = 1'b1; end
        for (int k = 3; k <= 12; k++) begin
            code = map[2*(k-3) +: 2];
            for (int c = 0; c < 2; c++) begin
                if (int'(code) == c + 1 && !seen[c]) begin
                    seen[c] = 1;
                    if (m_full[c]) begin tag[15-k] = 1'b1; first[c] = k; end
                end
            end
        end
        tag[15] = |tag[14:0];
        frame[255:240] = tag;
        if (cmd) begin frame[239:220] = a; frame[219:200] = d; end
        for (int c = 0; c < 2; c++)
            if (first[c] != 0) frame[255-16-20*(first[c]-1) -: 20] = m_data[c];
    endtask

    task automatic choose(input int n, output logic [19:0] map, output bit cmd, output logic [19:0] a,
                          output logic [19:0] d, output bit wr [2], output logic [19:0] wd [2]);
        map = $urandom; cmd = $urandom_range(1, 0) == 1;
        a = $urandom; d = $urandom;
        wr[0] = $urandom_range(9, 0) < 6; wr[1] = $urandom_range(9, 0) < 6;
        wd[0] = $urandom; wd[1] = $urandom;
        case (n)
            1: begin map = 20'h55555; cmd = 1; a = 20'h12345; d = 20'h0BEEF;
                     wr = '{1, 0}; wd[0] = 20'hABCDE; end
            2: begin map = 20'h80000; cmd = 0; wr = '{0, 1}; wd[1] = 20'h0F0F0; end
            3: begin map = 20'h00000; cmd = 0; wr = '{1, 1}; wd[0] = 20'h11111; wd[1] = 20'h22222; end
            4: begin map = 20'h00000; cmd = 0; wr = '{1, 0}; wd[0] = 20'h33333; end
            5: begin map = 20'h00018; cmd = 0; wr = '{0, 0}; end
            6: begin map = 20'hFFFFF; cmd = 0; wr = '{1, 1}; wd[0] = 20'h44444; wd[1] = 20'h55555; end
            7: begin map = 20'h01102; cmd = 1; a = 20'hFFFFF; d = 20'h00001; wr = '{0, 0}; end
            default: ;
        endcase
    endtask

    initial begin
        void'($urandom(32'd7321));
        m_full = '{0, 0};
        m_data = '{20'h0, 20'h0};
        repeat (3) @(negedge clk);
        // R9 reset state
        check(ac_sync == 1'b0, "R9 sync low in reset", 256'(ac_sync), 256'(0));
        check(ac_sdata == 1'b0, "R9 sdata low in reset", 256'(ac_sdata), 256'(0));
        check(cmd_ready == 1'b0, "R9 cmd_ready low in reset", 256'(cmd_ready), 256'(0));
        check(pcm_ready == 2'b11, "R9 pcm_ready high in reset", 256'(pcm_ready), 256'(3));
        rst_n = 1'b1;
        @(negedge clk);
        check(ac_sync == 1'b1, "R9 first sync one clock after reset", 256'(ac_sync), 256'(1));

        for (int n = 0; n < NFR; n++) begin
            logic [255:0] exp_f;
            logic [255:0] got;
            int           first [2];
            bit           pre [2];
            bit           sync_ok, cmd_ok;
            bit           rdy_ok [2];
            logic [19:0]  nx_map, nx_a, nx_d;
            bit           nx_cmd;
            bit           nx_wr [2];
            logic [19:0]  nx_wd [2];
            // phase 0: clock before the first tag bit
            check(cmd_ready == 1'b1, "R3 cmd_ready at frame boundary", 256'(cmd_ready), 256'(1));
            predict(slot_map, cmd_valid, cmd_addr, cmd_data, exp_f, first);
            pre = m_full;
            for (int c = 0; c < 2; c++) if (first[c] != 0) m_full[c] = 0;
            got = '0; sync_ok = 1; cmd_ok = 1; rdy_ok = '{1, 1};
            for (int p = 1; p <= 256; p++) begin
                @(negedge clk);
                got = {got[254:0], ac_sdata};
                if (p < 256) sync_ok &= (ac_sync == (p < 16));
                else         sync_ok &= (ac_sync == 1'b1);
                if (p < 256 && cmd_ready) cmd_ok = 0;
                if (p == 1) cmd_valid = 1'b0;
                if (p == 5) begin
                    // R8: mid-frame changes must not reach this frame
                    slot_map = $urandom; cmd_addr = $urandom; cmd_data = $urandom;
                end
                if (p < 240) begin
                    for (int c = 0; c < 2; c++) begin
                        bit er;
                        er = !pre[c] || (first[c] != 0 && p >= 16 + 20*(first[c]-1) + 1);
                        rdy_ok[c] &= (pcm_ready[c] == er);
                    end
                end
                if (p == 240) begin
                    choose(n + 1, nx_map, nx_cmd, nx_a, nx_d, nx_wr, nx_wd);
                    slot_map = nx_map; cmd_valid = nx_cmd; cmd_addr = nx_a; cmd_data = nx_d;
                    for (int c = 0; c < 2; c++) begin
                        check(pcm_ready[c] == !m_full[c], "R6 ready reflects empty holding register",
                              256'(pcm_ready[c]), 256'(!m_full[c]));
                        if (nx_wr[c]) begin
                            pcm_valid[c] = 1'b1;
                            pcm_data[c*20 +: 20] = nx_wd[c];
                            if (!m_full[c]) begin m_full[c] = 1; m_data[c] = nx_wd[c]; end
                        end
                    end
                end
                if (p == 241) pcm_valid = '0;
            end
            check(got == exp_f, "R2 R3 R4 R5 R6 R8 frame content", got, exp_f);
            check(sync_ok, "R1 sync timing and frame length", 256'(sync_ok), 256'(1));
            check(cmd_ok, "R3 cmd_ready only at boundary", 256'(cmd_ok), 256'(1));
            check(rdy_ok[0], "R7 channel A ready reassert timing", 256'(rdy_ok[0]), 256'(1));
            check(rdy_ok[1], "R7 channel B ready reassert timing", 256'(rdy_ok[1]), 256'(1));
        end
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #(64'd20 * 64'd100000);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule